// File: doc/BRIEF.md
# Programmable Group Delay with Late Mix

This block holds back a multi-channel stream of signed audio samples by a programmable number of sample periods. A control signal that is derived from the undelayed audio, for example the drive for a tracking power supply, can therefore arrive before the audio it serves. Once the main stream has been delayed, a second low-latency stream is added to it. That second stream passes through no delay at all.

Each channel has a shift memory of `MAX_DELAY` entries that advances on every sample strobe. A delay setting selects which past sample is read out. At a 48 kHz sample rate, the default depth of 24 samples covers 0 to 500 µs. The selected sample and the low-latency sample are summed with saturation, and the sum is loaded into an output register.

Top module: `gdm_top`

## Requirements
- R1: After reset `mix_o` is all zero and the delay memory holds zeros. Until enough strobes have arrived, a read of history that has not yet been written returns 0.
- R2: With delay setting 0, the output loaded on a strobe is the audio sample presented on that same strobe, plus the low-latency sample.
- R3: With delay setting d in 1..`MAX_DELAY`, the audio part of the output loaded on strobe n is the audio sample presented on strobe n-d.
- R4: A delay setting above `MAX_DELAY` behaves exactly as `MAX_DELAY`.
- R5: The low-latency sample of a strobe is added into the output loaded on that same strobe, whatever the delay setting.
- R6: When the sum exceeds +(2^23-1), the channel output is 24'h7FFFFF.
- R7: When the sum is below -2^23, the channel output is 24'h800000.
- R8: `mix_o` changes only on the clock edge at which `strobe_i` is high, and it then holds until the next strobe.
- R9: A new delay setting takes effect on the first strobe at which it is presented. The history already stored is used immediately.
- R10: Each channel occupies bits [24*c+23:24*c] of the packed buses and is processed independently of the other channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One-cycle sample-rate strobe |
| delay_i | input | 5 | Delay setting in samples |
| audio_i | input | 96 | Main audio samples, four signed 24-bit channels |
| lowlat_i | input | 96 | Low-latency samples, four signed 24-bit channels |
| mix_o | output | 96 | Registered delayed-plus-low-latency sum per channel |

## Verification
Three things can happen on the same strobe: a change of the delay setting, the arrival of a new sample, and saturation of the late sum. A change of setting must select from the history at once, in the same strobe that writes the newest entry. The bench provokes this by changing the delay setting from one strobe to the next, both upward and downward, and by driving full-scale audio together with full-scale low-latency values while the delay is nonzero. A reference history model in the bench predicts every output. A scoreboard compares each predicted value with the register contents on the cycle after the strobe.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
  localparam int unsigned SAMPLE_W = 24;

  function automatic logic [SAMPLE_W-1:0] sat_add(input logic [SAMPLE_W-1:0] a,
                                                  input logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] s;
    s = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
    if (s[SAMPLE_W] != s[SAMPLE_W-1])
      return s[SAMPLE_W] ? {1'b1, {(SAMPLE_W-1){1'b0}}} : {1'b0, {(SAMPLE_W-1){1'b1}}};
    return s[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/gdm_delay_line.sv
module gdm_delay_line #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 24,
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     tap_o
);
  localparam logic [DLY_W-1:0] DEPTH_C = DLY_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [DLY_W-1:0] eff_dly;
  logic [DLY_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (strobe_i) begin
      mem_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) mem_q[i] <= mem_q[i-1];
    end
  end

  // clamp setting, 0 = pass current sample
  always_comb begin
    eff_dly = (delay_i > DEPTH_C) ? DEPTH_C : delay_i;
    idx     = eff_dly - 1'b1;
    tap_o   = (eff_dly == '0) ? din_i : mem_q[idx];
  end

  p_shift_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> mem_q[0] == $past(din_i));
  p_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_i > DEPTH_C) |-> tap_o == mem_q[DEPTH-1]);
  p_hold_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(mem_q[0]));
endmodule

// File: rtl/gdm_mix_chan.sv
module gdm_mix_chan
  import gdm_pkg::*;
#(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned DLY_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [DLY_W-1:0]    delay_i,
  input  logic [SAMPLE_W-1:0] audio_i,
  input  logic [SAMPLE_W-1:0] lowlat_i,
  output logic [SAMPLE_W-1:0] mix_o
);
  logic [SAMPLE_W-1:0] tap;
  logic [SAMPLE_W-1:0] sum;
  logic [SAMPLE_W-1:0] mix_q;

  gdm_delay_line #(.W(SAMPLE_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .delay_i  (delay_i),
    .din_i    (audio_i),
    .tap_o    (tap)
  );

  assign sum = sat_add(tap, lowlat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mix_q <= '0;
    else if (strobe_i) mix_q <= sum;
  end

  assign mix_o = mix_q;

  p_sat_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !tap[SAMPLE_W-1] && !lowlat_i[SAMPLE_W-1]) |=> !mix_q[SAMPLE_W-1]);
  p_sat_neg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && tap[SAMPLE_W-1] && lowlat_i[SAMPLE_W-1]) |=> mix_q[SAMPLE_W-1]);
  p_zero_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && delay_i == '0 && lowlat_i == '0) |=> mix_q == $past(audio_i));
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(mix_q));
endmodule

// File: rtl/gdm_top.sv
module gdm_top
  import gdm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned MAX_DELAY = 24,
  parameter int unsigned DLY_W     = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic [DLY_W-1:0]           delay_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] audio_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] lowlat_i,
  output logic [NUM_CH*SAMPLE_W-1:0] mix_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gdm_mix_chan #(.DEPTH(MAX_DELAY), .DLY_W(DLY_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .delay_i  (delay_i),
      .audio_i  (audio_i[c*SAMPLE_W +: SAMPLE_W]),
      .lowlat_i (lowlat_i[c*SAMPLE_W +: SAMPLE_W]),
      .mix_o    (mix_o[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  p_bus_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(mix_o));
endmodule

// File: tb/tb_gdm_top.sv
`timescale 1ns/1ps
module tb_gdm_top;
  localparam int NCH = 4;
  localparam int W = 24;
  localparam int MAXD = 24;

  typedef struct {
    logic [NCH*W-1:0] exp;
    string            tag;
  } item_t;

  logic clk = 0, rst_n = 0, strobe = 0;
  logic [4:0] dly = '0;
  logic [NCH*W-1:0] aud = '0, ll = '0;
  logic [NCH*W-1:0] mix;

  int total = 0, bad = 0;
  item_t q[$];
  logic [W-1:0] hist [NCH][MAXD+1];
  bit done = 0;

  gdm_top dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .delay_i(dly),
    .audio_i(aud), .lowlat_i(ll), .mix_o(mix)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] sat(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
    longint s;
    s = longint'(a) + longint'(b);
    if (s > 8388607) return 24'h7FFFFF;
    if (s < -8388608) return 24'h800000;
    return s[W-1:0];
  endfunction

  task automatic check(input string tag, input logic [NCH*W-1:0] act, input logic [NCH*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one strobe, reference model pushes expected item
  task automatic push(input logic [4:0] d, input logic [NCH*W-1:0] a,
                      input logic [NCH*W-1:0] l, input string tag);
    item_t it;
    int e;
    @(negedge clk);
    dly = d; aud = a; ll = l; strobe = 1;
    e = (d > MAXD) ? MAXD : int'(d);
    for (int c = 0; c < NCH; c++) begin
      for (int k = MAXD; k > 0; k--) hist[c][k] = hist[c][k-1];
      hist[c][0] = a[c*W +: W];
      it.exp[c*W +: W] = sat(hist[c][e], l[c*W +: W]);
    end
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    strobe = 0;
    @(negedge clk);
  endtask

  function automatic logic [NCH*W-1:0] pat(input int n, input int base);
    logic [NCH*W-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*W +: W] = W'(base + n*16 + c*4096 + 1);
    return v;
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (strobe && rst_n) begin
        item_t it;
        @(negedge clk);
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard empty act=%h exp=none", mix);
        end else begin
          it = q.pop_front();
          check(it.tag, mix, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH*W-1:0] held;
    for (int c = 0; c < NCH; c++) for (int k = 0; k <= MAXD; k++) hist[c][k] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset output", mix, '0);
    rst_n = 1;
    @(negedge clk);

    // R1 + R3: unwritten history reads zero, then delayed samples
    for (int n = 0; n < 9; n++) push(5'd5, pat(n, 100), '0, "R1/R3 delay 5");
    // R2: zero delay
    for (int n = 0; n < 4; n++) push(5'd0, pat(n, 7000), '0, "R2 zero delay");
    // R9: settings change strobe by strobe, up and down
    push(5'd3, pat(1, 900), '0, "R9 change to 3");
    push(5'd10, pat(2, 900), '0, "R9 change to 10");
    push(5'd1, pat(3, 900), '0, "R9 change to 1");
    push(5'd24, pat(4, 900), '0, "R9 change to max");
    // R4: above max clamps
    for (int n = 0; n < 28; n++) push(5'd31, pat(n, 20000), '0, "R4 clamp 31");
    push(5'd25, pat(99, 5), '0, "R4 clamp 25");
    // R5: low-latency not delayed
    for (int n = 0; n < 6; n++) push(5'd4, pat(n, 300), pat(n, 55555), "R5 late mix");
    // R6/R7: saturation with delayed path involved
    push(5'd0, {NCH{24'h7FFFF0}}, {NCH{24'h000100}}, "R6 sat pos");
    push(5'd2, {NCH{24'h800010}}, {NCH{24'h7FFFFF}}, "R6 sat pos delayed");
    push(5'd0, {NCH{24'h800010}}, {NCH{24'hFFFF00}}, "R7 sat neg");
    push(5'd1, {NCH{24'h000001}}, {NCH{24'h800000}}, "R7 sat neg delayed");
    // R10: channels mixed signs
    push(5'd0, {24'h7FFFFF, 24'h800000, 24'h000010, 24'hFFFFF0},
               {24'h000001, 24'hFFFFFF, 24'h000020, 24'h000030}, "R10 channel independence");
    // R8: hold between strobes
    held = mix;
    dly = 5'd0; aud = '1; ll = '1;
    repeat (6) @(negedge clk);
    check("R8 hold", mix, held);

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover act=%0d exp=0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule